// File: doc/BRIEF.md
# Scanline Table-Driven Transfer Engine

This block moves a few bytes per display line for up to eight channels, each steered by a list kept in memory. A frame-start pulse primes every enabled channel: it reads the first line-count byte from the channel's list and, for channels in indirect mode, a 16-bit pointer to the data. Each later line pulse runs a burst of transfers between the wide memory side and the narrow peripheral side. It then steps each channel's line counter and fetches the next list entry when the counter's group runs out.

The line-count byte carries a repeat flag in bit 7 and a line count in bits 6:0. With the flag clear, the channel transfers on the first line of the group only. With the flag set, it transfers on every line of the group. A count byte of zero ends the channel's list for the rest of the frame. The engine uses one narrow memory port for both list fetches and data moves. It raises a one-cycle done pulse when the work for a pulse is finished, and a per-channel cancel strobe that tells the block-transfer unit to drop any pending bulk move on that channel.

Top module: `hdma_line_engine`

## Requirements
- R1: After synchronous reset, busy, done, mem_req and every dma_cancel bit are 0, and the engine stays idle until a pulse arrives.
- R2: A frame-start pulse clears every channel's transfer-pending and ended flags. With an all-zero enable mask it issues no memory access and gives only the done pulse.
- R3: At frame start, each enabled channel is handled in ascending order. Its cancel bit strobes, and its count byte is read from {a_bank, a_addr}. The list pointer becomes a_addr+1. In indirect mode two more bytes follow, low and then high, forming the data pointer.
- R4: On a line pulse, every enabled channel whose list has not ended and whose transfer is pending moves 1, 2, 2, 4, 4, 4, 2 or 4 bytes for mode 0 to 7. Byte j goes to peripheral address b_base plus an offset. By mode the offsets are: 0:{0}, 1:{0,1}, 2:{0,0}, 3:{0,0,1,1}, 4:{0,1,2,3}, 5:{0,1,0,1}, 6:{0,0}, 7:{0,0,1,1}. mem_b_to_a carries the channel's direction bit.
- R5: The memory address of a moved byte is {ind_bank, data pointer} in indirect mode and {a_bank, list pointer} otherwise, and that pointer steps by one per byte.
- R6: After the copies, each live channel decrements its count, and transfer-pending takes bit 7 of the new value. When bits 6:0 of the new value are zero, the next count byte is read at {a_bank, list pointer}, the pointer steps, and transfer-pending is set.
- R7: A count byte of zero ends the channel, and it then makes no access on any line pulse until the next frame start.
- R8: When a reload in indirect mode reads a zero count, the highest-numbered live channel reads only the high pointer byte, with the low byte forced to 0. Any other channel reads both bytes.
- R9: On a line pulse, all copies of all channels, in ascending channel order, come before any count update. The updates also run in ascending order.
- R10: The enable mask is sampled when a pulse is accepted, and changes during the burst have no effect. Every channel enabled in that sample strobes its cancel bit during the line pulse, whether or not its list has ended.
- R11: Each accepted pulse ends with exactly one done cycle, and pulses that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_pulse | input | 1 | Frame-start request |
| line_pulse | input | 1 | Per-line request |
| hdma_en | input | NUM_CH | Per-channel enable mask |
| cfg_mode | input | NUM_CH*3 | Transfer mode per channel |
| cfg_indirect | input | NUM_CH | Indirect-list flag per channel |
| cfg_b_to_a | input | NUM_CH | Direction: 1 moves peripheral to memory |
| cfg_b_base | input | NUM_CH*8 | Peripheral base address per channel |
| cfg_a_bank | input | NUM_CH*8 | Bank of the list |
| cfg_a_addr | input | NUM_CH*16 | Start of the list |
| cfg_ind_bank | input | NUM_CH*8 | Bank of indirect data |
| mem_rdata | input | 8 | Read data for the current access, same cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_is_xfer | output | 1 | 1: data move, 0: list fetch |
| mem_addr | output | 24 | Bank and offset of the access |
| mem_baddr | output | 8 | Peripheral address of a data move (0 on fetches) |
| mem_b_to_a | output | 1 | Direction of a data move (0 on fetches) |
| dma_cancel | output | NUM_CH | Strobe to drop a pending bulk move |
| busy | output | 1 | Engine is working on a pulse |
| done | output | 1 | One-cycle end-of-work strobe |

## Verification
The bench builds the engine with NUM_CH set to 4. This makes channel 3 the top index and lets a lower channel be the highest live one, so the shortened pointer fetch and its normal counterpart can both be shown with two active channels. Two table sets are used. One covers a direct two-byte channel with a non-repeat group and a repeat group, and an indirect channel that ends as the top live channel. The other covers a peripheral-to-memory four-offset channel in repeat mode and an indirect channel that ends below the top live channel. Directed runs change the mask and pulse again mid-burst, and give a frame start with nothing enabled.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

    localparam int OFS_W   = 16;
    localparam int BANK_W  = 8;
    localparam int BREG_W  = 8;
    localparam int DATA_W  = 8;
    localparam int MODE_W  = 3;
    localparam int MADDR_W = BANK_W + OFS_W;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLR,
        OP_START,
        OP_IND_LO,
        OP_IND_HI,
        OP_IND_HIZ,
        OP_XSTEP,
        OP_DEC,
        OP_RELOAD
    } ch_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_I_CH,
        S_I_CNT,
        S_I_LO,
        S_I_HI,
        S_C_CH,
        S_C_XF,
        S_U_CH,
        S_U_CNT,
        S_U_LO,
        S_U_HI,
        S_U_HZ,
        S_DONE
    } seq_st_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              indirect;
        logic              b_to_a;
        logic [BREG_W-1:0] b_base;
        logic [BANK_W-1:0] a_bank;
        logic [OFS_W-1:0]  a_addr;
        logic [BANK_W-1:0] ind_bank;
    } ch_cfg_t;

    typedef struct packed {
        logic [OFS_W-1:0]  tbl;
        logic [OFS_W-1:0]  ind;
        logic [DATA_W-1:0] rep;
        logic              dox;
        logic              term;
    } ch_st_t;

    function automatic logic [2:0] bytes_per_line(input logic [MODE_W-1:0] m);
        case (m)
            3'd0:                 return 3'd1;
            3'd1, 3'd2, 3'd6:     return 3'd2;
            default:              return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] b_offset(input logic [MODE_W-1:0] m,
                                            input logic [1:0] j);
        case (m)
            3'd1, 3'd5:  return {1'b0, j[0]};
            3'd3, 3'd7:  return {1'b0, j[1]};
            3'd4:        return j;
            default:     return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/hdma_chan.sv
module hdma_chan
    import hdma_pkg::*;
#(
    parameter int CW  = 3,
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_op_e            op,
    input  logic [CW-1:0]     op_ch,
    input  logic [DATA_W-1:0] rdata,
    input  ch_cfg_t           cfg,
    output ch_st_t            st
);

    ch_st_t             q;
    logic               hit;
    logic [DATA_W-1:0]  rep_m1;

    assign hit    = (op == OP_CLR) || (op_ch == CW'(IDX));
    assign rep_m1 = q.rep - 1'b1;
    assign st     = q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (hit) begin
            case (op)
                OP_CLR: begin
                    q.dox  <= 1'b0;
                    q.term <= 1'b0;
                end
                OP_START: begin
                    q.tbl  <= cfg.a_addr + 1'b1;
                    q.rep  <= rdata;
                    q.term <= (rdata == '0);
                    q.dox  <= 1'b1;
                end
                OP_IND_LO: begin
                    q.ind[7:0] <= rdata;
                    q.tbl      <= q.tbl + 1'b1;
                end
                OP_IND_HI: begin
                    q.ind[OFS_W-1:8] <= rdata;
                    q.tbl            <= q.tbl + 1'b1;
                end
                OP_IND_HIZ: begin
                    q.ind <= {rdata, 8'h00};
                    q.tbl <= q.tbl + 1'b1;
                end
                OP_XSTEP: begin
                    if (cfg.indirect) q.ind <= q.ind + 1'b1;
                    else              q.tbl <= q.tbl + 1'b1;
                end
                OP_DEC: begin
                    q.rep <= rep_m1;
                    q.dox <= rep_m1[DATA_W-1];
                end
                OP_RELOAD: begin
                    q.rep  <= rdata;
                    q.tbl  <= q.tbl + 1'b1;
                    q.term <= (rdata == '0);
                    q.dox  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R7
    term_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q.term && op != OP_CLR && !(hit && (op == OP_START || op == OP_RELOAD)))
        |=> q.term);

    // R5
    ind_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && op == OP_XSTEP && cfg.indirect)
        |=> (q.ind == $past(q.ind) + 1'b1) && $stable(q.tbl));

    // R6
    rep_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && op == OP_DEC) |=> (q.rep == $past(q.rep) - 1'b1));

endmodule

// File: rtl/hdma_seq.sv
module hdma_seq
    import hdma_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CW     = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_pulse,
    input  logic               line_pulse,
    input  logic [NUM_CH-1:0]  hdma_en,
    input  ch_cfg_t            cfg [NUM_CH],
    input  ch_st_t             chs [NUM_CH],
    input  logic [DATA_W-1:0]  rdata,
    output ch_op_e             op,
    output logic [CW-1:0]      op_ch,
    output logic               mem_req,
    output logic               mem_is_xfer,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [BREG_W-1:0]  mem_baddr,
    output logic               mem_b_to_a,
    output logic [NUM_CH-1:0]  cancel,
    output logic               busy,
    output logic               done
);

    localparam logic [CW-1:0] TOP_IDX = CW'(NUM_CH - 1);

    seq_st_e            st_q, st_d;
    logic [CW-1:0]      c_q, c_d, last_q, last_d, last_live;
    logic [1:0]         j_q, j_d;
    logic [NUM_CH-1:0]  en_q, en_d;
    ch_cfg_t            cc;
    ch_st_t             cs;
    logic [DATA_W-1:0]  rep_m1;
    logic               at_end;
    logic [2:0]         len;

    always_comb begin
        last_live = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hdma_en[i] && !chs[i].term) last_live = CW'(i);
        end
    end

    assign cc     = cfg[c_q];
    assign cs     = chs[c_q];
    assign rep_m1 = cs.rep - 1'b1;
    assign at_end = (c_q == TOP_IDX);
    assign len    = bytes_per_line(cc.mode);
    assign busy   = (st_q != S_IDLE);

    always_comb begin
        op          = OP_NONE;
        op_ch       = c_q;
        mem_req     = 1'b0;
        mem_is_xfer = 1'b0;
        mem_addr    = '0;
        mem_baddr   = '0;
        mem_b_to_a  = 1'b0;
        cancel      = '0;
        done        = 1'b0;
        st_d        = st_q;
        c_d         = c_q;
        j_d         = j_q;
        en_d        = en_q;
        last_d      = last_q;
        case (st_q)
            S_IDLE: begin
                if (init_pulse) begin
                    op   = OP_CLR;
                    en_d = hdma_en;
                    c_d  = '0;
                    st_d = (hdma_en == '0) ? S_DONE : S_I_CH;
                end else if (line_pulse) begin
                    en_d   = hdma_en;
                    c_d    = '0;
                    last_d = last_live;
                    st_d   = (hdma_en == '0) ? S_DONE : S_C_CH;
                end
            end
            S_I_CH: begin
                if (en_q[c_q]) begin
                    cancel[c_q] = 1'b1;
                    st_d        = S_I_CNT;
                end else if (at_end) begin
                    st_d = S_DONE;
                end else begin
                    c_d = c_q + 1'b1;
                end
            end
            S_I_CNT: begin
                mem_req  = 1'b1;
                mem_addr = {cc.a_bank, cc.a_addr};
                op       = OP_START;
                if (cc.indirect) begin
                    st_d = S_I_LO;
                end else if (at_end) begin
                    st_d = S_DONE;
                end else begin
                    c_d  = c_q + 1'b1;
                    st_d = S_I_CH;
                end
            end
            S_I_LO: begin
                mem_req  = 1'b1;
                mem_addr = {cc.a_bank, cs.tbl};
                op       = OP_IND_LO;
                st_d     = S_I_HI;
            end
            S_I_HI: begin
                mem_req  = 1'b1;
                mem_addr = {cc.a_bank, cs.tbl};
                op       = OP_IND_HI;
                if (at_end) begin
                    st_d = S_DONE;
                end else begin
                    c_d  = c_q + 1'b1;
                    st_d = S_I_CH;
                end
            end
            S_C_CH: begin
                if (en_q[c_q]) cancel[c_q] = 1'b1;
                if (en_q[c_q] && !cs.term && cs.dox) begin
                    j_d  = '0;
                    st_d = S_C_XF;
                end else if (at_end) begin
                    c_d  = '0;
                    st_d = S_U_CH;
                end else begin
                    c_d = c_q + 1'b1;
                end
            end
            S_C_XF: begin
                mem_req     = 1'b1;
                mem_is_xfer = 1'b1;
                mem_addr    = cc.indirect ? {cc.ind_bank, cs.ind} : {cc.a_bank, cs.tbl};
                mem_baddr   = cc.b_base + BREG_W'(b_offset(cc.mode, j_q));
                mem_b_to_a  = cc.b_to_a;
                op          = OP_XSTEP;
                if ({1'b0, j_q} == len - 3'd1) begin
                    j_d = '0;
                    if (at_end) begin
                        c_d  = '0;
                        st_d = S_U_CH;
                    end else begin
                        c_d  = c_q + 1'b1;
                        st_d = S_C_CH;
                    end
                end else begin
                    j_d = j_q + 1'b1;
                end
            end
            S_U_CH: begin
                if (en_q[c_q] && !cs.term) begin
                    op = OP_DEC;
                end
                if (en_q[c_q] && !cs.term && rep_m1[DATA_W-2:0] == '0) begin
                    st_d = S_U_CNT;
                end else if (at_end) begin
                    st_d = S_DONE;
                end else begin
                    c_d = c_q + 1'b1;
                end
            end
            S_U_CNT: begin
                mem_req  = 1'b1;
                mem_addr = {cc.a_bank, cs.tbl};
                op       = OP_RELOAD;
                if (cc.indirect) begin
                    st_d = (rdata == '0 && c_q == last_q) ? S_U_HZ : S_U_LO;
                end else if (at_end) begin
                    st_d = S_DONE;
                end else begin
                    c_d  = c_q + 1'b1;
                    st_d = S_U_CH;
                end
            end
            S_U_LO: begin
                mem_req  = 1'b1;
                mem_addr = {cc.a_bank, cs.tbl};
                op       = OP_IND_LO;
                st_d     = S_U_HI;
            end
            S_U_HI, S_U_HZ: begin
                mem_req  = 1'b1;
                mem_addr = {cc.a_bank, cs.tbl};
                op       = (st_q == S_U_HZ) ? OP_IND_HIZ : OP_IND_HI;
                if (at_end) begin
                    st_d = S_DONE;
                end else begin
                    c_d  = c_q + 1'b1;
                    st_d = S_U_CH;
                end
            end
            S_DONE: begin
                done = 1'b1;
                st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            c_q    <= '0;
            j_q    <= '0;
            en_q   <= '0;
            last_q <= '0;
        end else begin
            st_q   <= st_d;
            c_q    <= c_d;
            j_q    <= j_d;
            en_q   <= en_d;
            last_q <= last_d;
        end
    end

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    // R10
    en_snap_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && st_q != S_DONE) |=> $stable(en_q));

    // R4
    xfer_len_chk: assert property (@(posedge clk) disable iff (rst)
        mem_is_xfer |-> ({1'b0, j_q} < len));

    // R9
    upd_no_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q inside {S_U_CH, S_U_CNT, S_U_LO, S_U_HI, S_U_HZ}) |=> !mem_is_xfer);

endmodule

// File: rtl/hdma_line_engine.sv
module hdma_line_engine
    import hdma_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       init_pulse,
    input  logic                       line_pulse,
    input  logic [NUM_CH-1:0]          hdma_en,
    input  logic [NUM_CH*MODE_W-1:0]   cfg_mode,
    input  logic [NUM_CH-1:0]          cfg_indirect,
    input  logic [NUM_CH-1:0]          cfg_b_to_a,
    input  logic [NUM_CH*BREG_W-1:0]   cfg_b_base,
    input  logic [NUM_CH*BANK_W-1:0]   cfg_a_bank,
    input  logic [NUM_CH*OFS_W-1:0]    cfg_a_addr,
    input  logic [NUM_CH*BANK_W-1:0]   cfg_ind_bank,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic                       mem_req,
    output logic                       mem_is_xfer,
    output logic [MADDR_W-1:0]         mem_addr,
    output logic [BREG_W-1:0]          mem_baddr,
    output logic                       mem_b_to_a,
    output logic [NUM_CH-1:0]          dma_cancel,
    output logic                       busy,
    output logic                       done
);

    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    ch_cfg_t        cfg [NUM_CH];
    ch_st_t         chs [NUM_CH];
    ch_op_e         op;
    logic [CW-1:0]  op_ch;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign cfg[g].mode     = cfg_mode[g*MODE_W +: MODE_W];
        assign cfg[g].indirect = cfg_indirect[g];
        assign cfg[g].b_to_a   = cfg_b_to_a[g];
        assign cfg[g].b_base   = cfg_b_base[g*BREG_W +: BREG_W];
        assign cfg[g].a_bank   = cfg_a_bank[g*BANK_W +: BANK_W];
        assign cfg[g].a_addr   = cfg_a_addr[g*OFS_W +: OFS_W];
        assign cfg[g].ind_bank = cfg_ind_bank[g*BANK_W +: BANK_W];

        hdma_chan #(.CW(CW), .IDX(g)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .op    (op),
            .op_ch (op_ch),
            .rdata (mem_rdata),
            .cfg   (cfg[g]),
            .st    (chs[g])
        );
    end

    hdma_seq #(.NUM_CH(NUM_CH), .CW(CW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .init_pulse  (init_pulse),
        .line_pulse  (line_pulse),
        .hdma_en     (hdma_en),
        .cfg         (cfg),
        .chs         (chs),
        .rdata       (mem_rdata),
        .op          (op),
        .op_ch       (op_ch),
        .mem_req     (mem_req),
        .mem_is_xfer (mem_is_xfer),
        .mem_addr    (mem_addr),
        .mem_baddr   (mem_baddr),
        .mem_b_to_a  (mem_b_to_a),
        .cancel      (dma_cancel),
        .busy        (busy),
        .done        (done)
    );

    // R1
    req_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req || dma_cancel != '0) |-> busy && !done);

endmodule

// File: tb/tb_hdma_line_engine.sv
`timescale 1ns/1ps
module tb_hdma_line_engine;

    localparam int N = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst, init_pulse, line_pulse;
    logic [N-1:0]    hdma_en;
    logic [N*3-1:0]  cfg_mode;
    logic [N-1:0]    cfg_indirect, cfg_b_to_a;
    logic [N*8-1:0]  cfg_b_base, cfg_a_bank, cfg_ind_bank;
    logic [N*16-1:0] cfg_a_addr;
    logic [7:0]      mem_rdata;
    logic            mem_req, mem_is_xfer, mem_b_to_a, busy, done;
    logic [23:0]     mem_addr;
    logic [7:0]      mem_baddr;
    logic [N-1:0]    dma_cancel;

    hdma_line_engine #(.NUM_CH(N)) dut (.*);

    logic [7:0] mem [0:4095];
    assign mem_rdata = mem[mem_addr[11:0]];

    // entry: {b_to_a, is_xfer, baddr, addr[15:0]}
    localparam logic [25:0] EXP [0:29] = '{
        {1'b0,1'b0,8'h00,16'h0100}, {1'b0,1'b0,8'h00,16'h0200},
        {1'b0,1'b0,8'h00,16'h0201}, {1'b0,1'b0,8'h00,16'h0202},
        {1'b0,1'b1,8'h10,16'h0101}, {1'b0,1'b1,8'h11,16'h0102},
        {1'b0,1'b1,8'h20,16'h0300}, {1'b0,1'b0,8'h00,16'h0203},
        {1'b0,1'b0,8'h00,16'h0204}, {1'b0,1'b0,8'h00,16'h0103},
        {1'b0,1'b1,8'h10,16'h0104}, {1'b0,1'b1,8'h11,16'h0105},
        {1'b0,1'b0,8'h00,16'h0106}, {1'b0,1'b0,8'h00,16'h0500},
        {1'b0,1'b0,8'h00,16'h0501}, {1'b0,1'b0,8'h00,16'h0502},
        {1'b0,1'b0,8'h00,16'h0400}, {1'b0,1'b1,8'h30,16'h0600},
        {1'b1,1'b1,8'h40,16'h0401}, {1'b1,1'b1,8'h41,16'h0402},
        {1'b1,1'b1,8'h42,16'h0403}, {1'b1,1'b1,8'h43,16'h0404},
        {1'b0,1'b0,8'h00,16'h0503}, {1'b0,1'b0,8'h00,16'h0504},
        {1'b0,1'b0,8'h00,16'h0505}, {1'b1,1'b1,8'h40,16'h0405},
        {1'b1,1'b1,8'h41,16'h0406}, {1'b1,1'b1,8'h42,16'h0407},
        {1'b1,1'b1,8'h43,16'h0408}, {1'b0,1'b0,8'h00,16'h0409}
    };

    localparam int         NSTEP = 8;
    localparam bit         ST_INIT [0:NSTEP-1] = '{1, 0, 0, 0, 0, 1, 0, 0};
    localparam logic [3:0] ST_MASK [0:NSTEP-1] = '{4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'h3, 4'h3, 4'h1};
    localparam int         ST_N    [0:NSTEP-1] = '{4, 5, 1, 3, 0, 4, 8, 0};
    localparam int         ST_BASE [0:NSTEP-1] = '{0, 4, 9, 10, 13, 13, 17, 25};
    localparam logic [3:0] ST_CAN  [0:NSTEP-1] = '{4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'h3, 4'h3, 4'h1};
    string st_tag [0:NSTEP-1] = '{"R3", "R8", "R6", "R4", "R7", "R5", "R9", "R10"};

    int n_chk = 0;
    int n_bad = 0;
    logic [25:0]  got [0:63];
    int           got_n;
    logic [N-1:0] got_cancel;
    bit           got_done;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_ch(input int i, input logic [2:0] mode, input bit ind,
                          input bit dir, input logic [7:0] bb, input logic [15:0] aa);
        cfg_mode[i*3 +: 3]      = mode;
        cfg_indirect[i]         = ind;
        cfg_b_to_a[i]           = dir;
        cfg_b_base[i*8 +: 8]    = bb;
        cfg_a_bank[i*8 +: 8]    = 8'h00;
        cfg_a_addr[i*16 +: 16]  = aa;
        cfg_ind_bank[i*8 +: 8]  = 8'h00;
    endtask

    task automatic run_pulse(input bit is_init, input logic [N-1:0] mask,
                             input int chg_at, input logic [N-1:0] chg_mask);
        got_n = 0; got_cancel = '0; got_done = 0;
        @(negedge clk);
        hdma_en = mask;
        if (is_init) init_pulse = 1'b1; else line_pulse = 1'b1;
        @(negedge clk);
        init_pulse = 1'b0; line_pulse = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (mem_req && got_n < 64) begin
                got[got_n] = {mem_b_to_a, mem_is_xfer, mem_baddr, mem_addr[15:0]};
                got_n++;
            end
            got_cancel |= dma_cancel;
            if (done) begin
                got_done = 1;
                break;
            end
            if (k == chg_at) begin
                hdma_en    = chg_mask;
                line_pulse = 1'b1;
            end else begin
                line_pulse = 1'b0;
            end
            @(negedge clk);
        end
        line_pulse = 1'b0;
    endtask

    task automatic cmp_log(input string tag, input int base, input int n);
        chk(tag, "done seen (R11)", 32'(got_done), 32'd1);
        chk(tag, "access count", 32'(got_n), 32'(n));
        for (int i = 0; i < n; i++) begin
            if (i < got_n) chk(tag, "access", 32'(got[i]), 32'(EXP[base + i]));
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; init_pulse = 1'b0; line_pulse = 1'b0; hdma_en = '0;
        cfg_mode = '0; cfg_indirect = '0; cfg_b_to_a = '0; cfg_b_base = '0;
        cfg_a_bank = '0; cfg_a_addr = '0; cfg_ind_bank = '0;
        for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
        mem[12'h100] = 8'h02; mem[12'h101] = 8'hd0; mem[12'h102] = 8'hd1;
        mem[12'h103] = 8'h81; mem[12'h104] = 8'he0; mem[12'h105] = 8'he1;
        mem[12'h106] = 8'h00;
        mem[12'h200] = 8'h01; mem[12'h201] = 8'h00; mem[12'h202] = 8'h03;
        mem[12'h203] = 8'h00; mem[12'h204] = 8'h55;
        mem[12'h400] = 8'h82;
        for (int a = 1; a <= 8; a++) mem[12'h400 + a] = 8'(8'h60 + a);
        mem[12'h409] = 8'h00;
        mem[12'h500] = 8'h01; mem[12'h501] = 8'h00; mem[12'h502] = 8'h06;
        mem[12'h503] = 8'h00; mem[12'h504] = 8'h11; mem[12'h505] = 8'h22;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "dma_cancel", 32'(dma_cancel), 32'd0);

        for (int s = 0; s < NSTEP; s++) begin
            if (s == 0) begin
                set_ch(0, 3'd1, 1'b0, 1'b0, 8'h10, 16'h0100);
                set_ch(1, 3'd0, 1'b0, 1'b0, 8'h00, 16'h0000);
                set_ch(2, 3'd0, 1'b1, 1'b0, 8'h20, 16'h0200);
                set_ch(3, 3'd0, 1'b0, 1'b0, 8'h00, 16'h0000);
            end
            if (s == 5) begin
                set_ch(0, 3'd0, 1'b1, 1'b0, 8'h30, 16'h0500);
                set_ch(1, 3'd4, 1'b0, 1'b1, 8'h40, 16'h0400);
            end
            run_pulse(ST_INIT[s], ST_MASK[s], -1, '0);
            cmp_log(st_tag[s], ST_BASE[s], ST_N[s]);
            chk(st_tag[s], "cancel strobes (R10)", 32'(got_cancel), 32'(ST_CAN[s]));
        end

        // R10 / R11: mask change and extra pulse during the burst
        run_pulse(1'b0, 4'h3, 2, 4'h1);
        cmp_log("R10", 25, 5);
        chk("R10", "cancel from sampled mask", 32'(got_cancel), 32'h3);
        begin
            int stray = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (busy || mem_req) stray++;
            end
            chk("R11", "activity after ignored pulse", 32'(stray), 32'd0);
        end

        // R2: frame start with nothing enabled
        run_pulse(1'b1, 4'h0, -1, '0);
        cmp_log("R2", 0, 0);
        chk("R2", "cancel", 32'(got_cancel), 32'd0);

        summary();
        $finish;
    end

endmodule